// File: doc/BRIEF.md
# Conditional Branch Resolver

This block decides, once per instruction, whether a relative branch of a 32-bit processor is taken and where fetch goes next. It holds two architectural registers: a loop counter and a return-address register. A conditional branch combines two tests. The first test looks at one bit of the condition register, chosen by a bit index. The second test looks at the loop counter, which the instruction may decrement as a side effect. Both tests must pass for the branch to be taken.

A five-bit option field chooses how each test behaves. Its top two bits say whether the chosen condition bit must be clear, must be set, or is ignored. Its next two bits say whether the counter is decremented and which count value allows the branch. Its lowest bit has no effect.

The branch target is the current PC plus a sign-extended word displacement. A link flag saves the address of the next instruction. Two load ports let software write either register directly, but a branch side effect on the same register in the same cycle takes priority.

Top module: `branch_resolve_unit`

## Requirements
- R1: After reset, the loop counter `ctr_q` and the return register `lr_q` both read 0.
- R2: The condition test is decided by option bits [4:3] and by `cond_sel`, where `cond_sel`=k picks `cond_reg[31-k]`, so index 0 is the MSB.
  - Code 0 passes only if the picked bit is 0.
  - Code 1 passes only if the picked bit is 1.
  - Codes 2 and 3 always pass.
- R3: Option bits [2:1] decide whether the counter changes.
  - Codes 0 and 1 decrement the counter by one at the clock edge, modulo 2^32, whether or not the branch is taken.
  - Codes 2 and 3 leave the counter unchanged.
- R4: The count test uses the counter value held before the instruction.
  - Count code 0 passes only if that value is not 1, so a counter of 0 passes and wraps to 0xFFFFFFFF.
  - Count code 1 passes only if that value is exactly 1.
  - Codes 2 and 3 always pass.
- R5: A valid conditional branch is taken exactly when both the condition test and the count test pass.
- R6: `next_pc` is `pc + (sign_extend(disp) << 2)` when the branch is taken, and `pc + 4` otherwise.
- R7: When `link_en` is high on a valid instruction, `lr_q` becomes `pc + 4` at the clock edge, whether or not the branch is taken. When `link_en` is low, `lr_q` is left unchanged.
- R8: When `is_uncond` is high on a valid instruction, the branch is always taken, the counter is not changed, and `link_en` still applies.
- R9: The load ports write their register at the clock edge. If the same register is also updated by the branch in that cycle, the branch update wins.
- R10: Option bit 0 has no effect. When `instr_valid` is low, `taken` is 0 and neither register changes unless it is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | A branch is presented this cycle |
| is_uncond | input | 1 | Branch is unconditional |
| bo | input | 5 | Option field: [4:3] condition code, [2:1] count code, [0] unused |
| cond_sel | input | 5 | Condition bit index, 0 = MSB |
| link_en | input | 1 | Save return address |
| pc | input | 32 | Address of the branch |
| disp | input | 24 | Signed word displacement |
| cond_reg | input | 32 | Condition register |
| ctr_load | input | 1 | Write the counter |
| ctr_load_data | input | 32 | Counter write value |
| lr_load | input | 1 | Write the return register |
| lr_load_data | input | 32 | Return register write value |
| taken | output | 1 | Branch taken |
| next_pc | output | 32 | Next fetch address |
| ctr_q | output | 32 | Loop counter |
| lr_q | output | 32 | Return register |

## Verification
The main test is a full sweep over all four condition codes, all four count codes, link on and off, the condition bit clear and set, and a preloaded counter of 1 and of 2. This sweep shows whether the two tests are really combined by AND, and whether a decrement happens on a not-taken branch.

Further patterns cover the rest:
- A single condition bit is walked across several indices, which shows whether the bit order is reversed.
- A counter of 0 under count code 0 separates "not 1 before" from "nonzero before" and exposes the wrap.
- Loads that collide with branch updates on the same register check the priority rule.
- Idle cycles are presented with a decrementing option field, and option bit 0 is toggled.

// File: rtl/bru_pkg.sv
package bru_pkg;

    typedef enum logic [1:0] {
        CC_IF_CLEAR = 2'd0,
        CC_IF_SET   = 2'd1,
        CC_ALWAYS_A = 2'd2,
        CC_ALWAYS_B = 2'd3
    } cond_code_e;

    typedef enum logic [1:0] {
        CT_DEC_NOT_ONE = 2'd0,
        CT_DEC_IS_ONE  = 2'd1,
        CT_HOLD_A      = 2'd2,
        CT_HOLD_B      = 2'd3
    } count_code_e;

endpackage

// File: rtl/bru_cond_test.sv
module bru_cond_test
    import bru_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int BI_W = $clog2(XLEN)
) (
    input  cond_code_e        cc,
    input  logic [BI_W-1:0]   cond_sel,
    input  logic [XLEN-1:0]   cond_reg,
    output logic              cond_ok
);

    logic [BI_W-1:0] phys_idx;
    logic            picked;

    always_comb begin
        phys_idx = BI_W'(XLEN - 1) - cond_sel;
        picked   = cond_reg[phys_idx];
        unique case (cc)
            CC_IF_CLEAR: cond_ok = ~picked;
            CC_IF_SET:   cond_ok = picked;
            CC_ALWAYS_A,
            CC_ALWAYS_B: cond_ok = 1'b1;
        endcase
    end

endmodule

// File: rtl/bru_count_unit.sv
module bru_count_unit
    import bru_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  count_code_e      ct,
    input  logic             ld_en,
    input  logic [XLEN-1:0]  ld_data,
    output logic [XLEN-1:0]  ctr_q,
    output logic             cnt_ok
);

    logic dec_req;
    logic is_one;

    always_comb begin
        is_one  = (ctr_q == XLEN'(1));
        dec_req = 1'b0;
        unique case (ct)
            CT_DEC_NOT_ONE: begin
                cnt_ok  = ~is_one;
                dec_req = active;
            end
            CT_DEC_IS_ONE: begin
                cnt_ok  = is_one;
                dec_req = active;
            end
            CT_HOLD_A,
            CT_HOLD_B: cnt_ok = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       ctr_q <= '0;
        else if (dec_req) ctr_q <= ctr_q - XLEN'(1);
        else if (ld_en)   ctr_q <= ld_data;
    end

endmodule

// File: rtl/bru_link_unit.sv
module bru_link_unit #(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_wr,
    input  logic [XLEN-1:0]  link_val,
    input  logic             ld_en,
    input  logic [XLEN-1:0]  ld_data,
    output logic [XLEN-1:0]  lr_q
);

    always_ff @(posedge clk) begin
        if (!rst_n)       lr_q <= '0;
        else if (link_wr) lr_q <= link_val;
        else if (ld_en)   lr_q <= ld_data;
    end

endmodule

// File: rtl/bru_target_calc.sv
module bru_target_calc #(
    parameter int XLEN   = 32,
    parameter int DISP_W = 24
) (
    input  logic [XLEN-1:0]   pc,
    input  logic [DISP_W-1:0] disp,
    input  logic              take,
    output logic [XLEN-1:0]   seq_pc,
    output logic [XLEN-1:0]   next_pc
);

    localparam int PAD_W = XLEN - DISP_W - 2;

    logic [XLEN-1:0] byte_off;

    generate
        if (PAD_W > 0) begin : g_extend
            assign byte_off = {{PAD_W{disp[DISP_W-1]}}, disp, 2'b00};
        end else begin : g_trunc
            assign byte_off = {disp[XLEN-3:0], 2'b00};
        end
    endgenerate

    always_comb begin
        seq_pc  = pc + XLEN'(4);
        next_pc = take ? (pc + byte_off) : seq_pc;
    end

endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
    import bru_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int DISP_W = 24,
    localparam int BI_W  = $clog2(XLEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic              is_uncond,
    input  logic [4:0]        bo,
    input  logic [BI_W-1:0]   cond_sel,
    input  logic              link_en,
    input  logic [XLEN-1:0]   pc,
    input  logic [DISP_W-1:0] disp,
    input  logic [XLEN-1:0]   cond_reg,
    input  logic              ctr_load,
    input  logic [XLEN-1:0]   ctr_load_data,
    input  logic              lr_load,
    input  logic [XLEN-1:0]   lr_load_data,
    output logic              taken,
    output logic [XLEN-1:0]   next_pc,
    output logic [XLEN-1:0]   ctr_q,
    output logic [XLEN-1:0]   lr_q
);

    cond_code_e      cc;
    count_code_e     ct;
    logic            cond_ok;
    logic            cnt_ok;
    logic            cond_active;
    logic [XLEN-1:0] seq_pc;

    always_comb begin
        unique casez (bo)
            5'b00???: cc = CC_IF_CLEAR;
            5'b01???: cc = CC_IF_SET;
            5'b10???: cc = CC_ALWAYS_A;
            5'b11???: cc = CC_ALWAYS_B;
            default:  cc = CC_ALWAYS_A;
        endcase
        unique casez (bo)
            5'b??00?: ct = CT_DEC_NOT_ONE;
            5'b??01?: ct = CT_DEC_IS_ONE;
            5'b??10?: ct = CT_HOLD_A;
            5'b??11?: ct = CT_HOLD_B;
            default:  ct = CT_HOLD_A;
        endcase
    end

    assign cond_active = instr_valid & ~is_uncond;

    bru_cond_test #(.XLEN(XLEN)) u_cond (
        .cc       (cc),
        .cond_sel (cond_sel),
        .cond_reg (cond_reg),
        .cond_ok  (cond_ok)
    );

    bru_count_unit #(.XLEN(XLEN)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (cond_active),
        .ct      (ct),
        .ld_en   (ctr_load),
        .ld_data (ctr_load_data),
        .ctr_q   (ctr_q),
        .cnt_ok  (cnt_ok)
    );

    assign taken = instr_valid & (is_uncond | (cond_ok & cnt_ok));

    bru_target_calc #(.XLEN(XLEN), .DISP_W(DISP_W)) u_target (
        .pc      (pc),
        .disp    (disp),
        .take    (taken),
        .seq_pc  (seq_pc),
        .next_pc (next_pc)
    );

    bru_link_unit #(.XLEN(XLEN)) u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_wr  (instr_valid & link_en),
        .link_val (seq_pc),
        .ld_en    (lr_load),
        .ld_data  (lr_load_data),
        .lr_q     (lr_q)
    );

endmodule

// File: rtl/bru_checker.sv
module bru_checker #(
    parameter int XLEN   = 32,
    parameter int DISP_W = 24
) (
    input logic            clk,
    input logic            rst_n,
    input logic            instr_valid,
    input logic            is_uncond,
    input logic [4:0]      bo,
    input logic            link_en,
    input logic [XLEN-1:0] pc,
    input logic            ctr_load,
    input logic [XLEN-1:0] ctr_load_data,
    input logic            lr_load,
    input logic            taken,
    input logic [XLEN-1:0] next_pc,
    input logic [XLEN-1:0] ctr_q,
    input logic [XLEN-1:0] lr_q
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (ctr_q == '0 && lr_q == '0)); // R1

    AST_DEC_ON_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !is_uncond && !bo[2]) |=> ctr_q == $past(ctr_q) - XLEN'(1)); // R3

    AST_HOLD_ON_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && bo[2] && !ctr_load) |=> $stable(ctr_q)); // R3

    AST_ONE_BLOCKS_NZ: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !is_uncond && bo[2:1] == 2'b00 && ctr_q == XLEN'(1)) |-> !taken); // R4

    AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |-> next_pc == pc + XLEN'(4)); // R6

    AST_LINK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && link_en) |=> lr_q == $past(pc) + XLEN'(4)); // R7

    AST_LINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(instr_valid && link_en) && !lr_load |=> $stable(lr_q)); // R7

    AST_UNCOND_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && is_uncond) |-> taken); // R8

    AST_CTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_load && !(instr_valid && !is_uncond && !bo[2])) |=> ctr_q == $past(ctr_load_data)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid && !ctr_load) |-> !taken ##1 $stable(ctr_q)); // R10

endmodule

bind branch_resolve_unit bru_checker #(.XLEN(XLEN), .DISP_W(DISP_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_valid   (instr_valid),
    .is_uncond     (is_uncond),
    .bo            (bo),
    .link_en       (link_en),
    .pc            (pc),
    .ctr_load      (ctr_load),
    .ctr_load_data (ctr_load_data),
    .lr_load       (lr_load),
    .taken         (taken),
    .next_pc       (next_pc),
    .ctr_q         (ctr_q),
    .lr_q          (lr_q)
);

// File: tb/branch_resolve_unit_tb_top.sv
`timescale 1ns/1ps
module branch_resolve_unit_tb_top;

    localparam int PERIOD = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic        is_uncond = 1'b0;
    logic [4:0]  bo = '0;
    logic [4:0]  cond_sel = '0;
    logic        link_en = 1'b0;
    logic [31:0] pc = '0;
    logic [23:0] disp = '0;
    logic [31:0] cond_reg = '0;
    logic        ctr_load = 1'b0;
    logic [31:0] ctr_load_data = '0;
    logic        lr_load = 1'b0;
    logic [31:0] lr_load_data = '0;
    logic        taken;
    logic [31:0] next_pc;
    logic [31:0] ctr_q;
    logic [31:0] lr_q;

    always #(PERIOD/2) clk = ~clk;

    branch_resolve_unit dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .is_uncond(is_uncond),
        .bo(bo), .cond_sel(cond_sel), .link_en(link_en), .pc(pc), .disp(disp),
        .cond_reg(cond_reg), .ctr_load(ctr_load), .ctr_load_data(ctr_load_data),
        .lr_load(lr_load), .lr_load_data(lr_load_data), .taken(taken),
        .next_pc(next_pc), .ctr_q(ctr_q), .lr_q(lr_q)
    );

    typedef struct {
        bit          exp_taken;
        logic [31:0] exp_npc;
        logic [31:0] exp_ctr;
        logic [31:0] exp_lr;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    int          n_vec = 0;
    int          n_bad = 0;
    logic [31:0] m_ctr = '0;
    logic [31:0] m_lr  = '0;

    task automatic apply(input bit v, input bit unc, input logic [4:0] b, input logic [4:0] sel,
                         input bit lk, input logic [31:0] p, input logic [23:0] d,
                         input logic [31:0] cr, input bit cl, input logic [31:0] cld,
                         input bit ll, input logic [31:0] lld, input string tag);
        item_t it;
        bit c_ok, n_ok, dec;
        logic [31:0] off;
        @(negedge clk);
        case (b[4:3])
            2'd0:    c_ok = (cr[31 - int'(sel)] == 1'b0);
            2'd1:    c_ok = (cr[31 - int'(sel)] == 1'b1);
            default: c_ok = 1'b1;
        endcase
        case (b[2:1])
            2'd0:    n_ok = (m_ctr != 32'd1);
            2'd1:    n_ok = (m_ctr == 32'd1);
            default: n_ok = 1'b1;
        endcase
        dec = v && !unc && !b[2];
        off = {{6{d[23]}}, d, 2'b00};
        it.exp_taken = v && (unc || (c_ok && n_ok));
        it.exp_npc   = it.exp_taken ? p + off : p + 32'd4;
        it.exp_ctr   = dec ? m_ctr - 32'd1 : (cl ? cld : m_ctr);
        it.exp_lr    = (v && lk) ? p + 32'd4 : (ll ? lld : m_lr);
        it.tag       = tag;
        m_ctr = it.exp_ctr;
        m_lr  = it.exp_lr;
        instr_valid = v; is_uncond = unc; bo = b; cond_sel = sel; link_en = lk;
        pc = p; disp = d; cond_reg = cr; ctr_load = cl; ctr_load_data = cld;
        lr_load = ll; lr_load_data = lld;
        sb_q.push_back(it);
    endtask

    task automatic idle_load_ctr(input logic [31:0] val);
        apply(0, 0, 5'b0, 5'd0, 0, 32'h0, 24'h0, 32'h0, 1, val, 0, 32'h0, "R9 ctr load");
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(negedge clk);
            #4;
            if (sb_q.size() > 0) begin
                it = sb_q[0];
                n_vec++;
                if (taken !== it.exp_taken) begin
                    n_bad++;
                    $display("FAIL %s taken act=%0b exp=%0b", it.tag, taken, it.exp_taken);
                end
                if (next_pc !== it.exp_npc) begin
                    n_bad++;
                    $display("FAIL %s next_pc act=%h exp=%h", it.tag, next_pc, it.exp_npc);
                end
                @(posedge clk);
                #4;
                void'(sb_q.pop_front());
                if (ctr_q !== it.exp_ctr) begin
                    n_bad++;
                    $display("FAIL %s ctr act=%h exp=%h", it.tag, ctr_q, it.exp_ctr);
                end
                if (lr_q !== it.exp_lr) begin
                    n_bad++;
                    $display("FAIL %s lr act=%h exp=%h", it.tag, lr_q, it.exp_lr);
                end
            end
        end
    end

    initial begin : watchdog
        #(PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : driver
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, seen on an idle cycle
        apply(0, 0, 5'b0, 5'd0, 0, 32'h0, 24'h0, 32'h0, 0, 32'h0, 0, 32'h0, "R1 reset");
        // R8 / R6: unconditional forward, backward, with link
        apply(1, 1, 5'b00000, 5'd0, 0, 32'h1000, 24'h000010, 32'h0, 0, 32'h0, 0, 32'h0, "R8 uncond");
        apply(1, 1, 5'b00000, 5'd0, 1, 32'h2000, 24'hFFFFFF, 32'h0, 0, 32'h0, 0, 32'h0, "R6 R8 uncond link back");
        // R3 R4 R5 R7 R10: full sweep, option bit 0 toggled
        k = 0;
        for (int cc = 0; cc < 4; cc++)
            for (int cd = 0; cd < 4; cd++)
                for (int lk = 0; lk < 2; lk++)
                    for (int cond = 0; cond < 2; cond++)
                        for (int c = 1; c <= 2; c++) begin
                            idle_load_ctr(32'(c));
                            apply(1, 0, {2'(cc), 2'(cd), 1'(k)}, 5'd0, 1'(lk), 32'h4000 + 32'(k * 8),
                                  24'h000040, cond ? 32'h8000_0000 : 32'h0, 0, 32'h0, 0, 32'h0,
                                  "R3 R4 R5 R7 R10 sweep");
                            k++;
                        end
        // R2: bit index order
        for (int s = 0; s < 32; s += 7) begin
            apply(1, 0, 5'b01100, 5'(s), 0, 32'h8000, 24'h000002, 32'h1 << (31 - s), 0, 32'h0, 0, 32'h0, "R2 match");
            apply(1, 0, 5'b01100, 5'(s), 0, 32'h8000, 24'h000002, 32'h1 << s, 0, 32'h0, 0, 32'h0, "R2 mirror");
        end
        // R4: counter 0 under count code 0 wraps and branches
        idle_load_ctr(32'h0);
        apply(1, 0, 5'b10000, 5'd0, 0, 32'h100, 24'h000004, 32'h0, 0, 32'h0, 0, 32'h0, "R4 wrap");
        // R9: collisions and plain loads
        apply(1, 0, 5'b10000, 5'd0, 0, 32'h200, 24'h1, 32'h0, 1, 32'h55, 0, 32'h0, "R9 dec beats load");
        apply(1, 0, 5'b10100, 5'd0, 0, 32'h200, 24'h1, 32'h0, 1, 32'h77, 0, 32'h0, "R9 load with hold code");
        apply(1, 0, 5'b10100, 5'd0, 1, 32'h300, 24'h1, 32'h0, 0, 32'h0, 1, 32'hAA, "R9 link beats load");
        apply(0, 0, 5'b00000, 5'd0, 0, 32'h0, 24'h0, 32'h0, 0, 32'h0, 1, 32'hBEEF, "R9 lr load");
        // R10: idle cycle with a decrementing, linking pattern does nothing
        apply(0, 0, 5'b10000, 5'd3, 1, 32'h900, 24'h5, 32'hFFFF_FFFF, 0, 32'h0, 0, 32'h0, "R10 idle");
        apply(0, 0, 5'b00000, 5'd0, 0, 32'h0, 24'h0, 32'h0, 0, 32'h0, 0, 32'h0, "R10 idle tail");
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule